// File: doc/BRIEF.md
# Bit-Field and Byte Manipulation Unit

This unit is the execution slice of a 32-bit integer pipeline that handles bit-field and byte-level instructions. It takes two source operands, a shift-amount field, two field bounds and an operation code. It produces one result word and a field-error flag. Its operations are: leading-zero and leading-one counts, extracting and inserting a variable bit field, swapping the two bytes inside each halfword, and sign-extending the low byte or the low halfword.

The datapath is combinational. Its result is captured in one output register so that it can sit at the end of an execute stage. Field bounds that make no sense do not stop the unit. An extract that runs past the top bit, an insert whose upper bound is below its lower bound, an unknown shuffle selector and a reserved operation code all give a fixed, defined result and raise the error flag. The surrounding core decides whether to trap on that flag.

Top module: `bitfield_unit`

## Requirements
- R1: Outputs are registered. A change at the inputs appears on `result` and `field_err` after the next rising clock edge and not before it. While `rst_n` is low at a clock edge, both outputs clear to zero.
- R2: With `op_sel` = 0 (leading-zero count), `result` is 31 minus the index of the highest set bit of `src_a`, or 32 when `src_a` is zero. `field_err` is 0.
- R3: With `op_sel` = 1 (leading-one count), `result` is 31 minus the index of the highest clear bit of `src_a`, or 32 when `src_a` is all ones. `field_err` is 0.
- R4: With `op_sel` = 2 (extract) and `fld_lo + fld_hi` ≤ 31, `result` holds bits `fld_lo` up to `fld_lo + fld_hi` of `src_a`, moved down to bit 0, with zeros above. `fld_hi` is the field size minus one. `field_err` is 0.
- R5: With `op_sel` = 2 and `fld_lo + fld_hi` > 31, `field_err` is 1. `result` is `src_a` shifted right by `fld_lo` and masked to `fld_hi + 1` bits, with positions past bit 31 read as zero.
- R6: With `op_sel` = 3 (insert) and `fld_hi` ≥ `fld_lo`, `result` equals `src_b`, except that bits `fld_lo`..`fld_hi` are replaced by the low `fld_hi - fld_lo + 1` bits of `src_a`. `field_err` is 0.
- R7: With `op_sel` = 3 and `fld_hi` < `fld_lo`, `result` equals `src_b` unchanged and `field_err` is 1.
- R8: With `op_sel` = 4 (byte shuffle) and `shamt` = 0x02, result bytes 3,2,1,0 are `src_b` bytes 2,3,0,1. `field_err` is 0.
- R9: With `op_sel` = 4, `shamt` = 0x10 sign-extends `src_b[7:0]` and `shamt` = 0x18 sign-extends `src_b[15:0]` to 32 bits. `field_err` is 0.
- R10: With `op_sel` = 4 and any other `shamt`, or with `op_sel` = 5, 6 or 7, `result` is 0 and `field_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 3 | Operation code (0 lead-zero, 1 lead-one, 2 extract, 3 insert, 4 byte shuffle) |
| src_a | input | 32 | First source operand (counted, extracted from, or inserted from) |
| src_b | input | 32 | Second source operand (insert base, shuffle input) |
| shamt | input | 5 | Shuffle selector |
| fld_hi | input | 5 | Upper field bound (extract: size minus one; insert: top bit) |
| fld_lo | input | 5 | Lower field bound |
| result | output | 32 | Registered result |
| field_err | output | 1 | Registered illegal-field flag |

## Verification
On every cycle, the assertions check the following against the inputs of the previous cycle:
- the reset value and the one-cycle latency;
- that a top-bit-set word counts zero leading zeros and an all-ones word counts 32 leading ones;
- the count range;
- that the swap preserves the number of set bits, and the sign fill of both extends;
- the unchanged base and the flag for a reversed insert;
- the flag for an over-long extract;
- the zero result for reserved codes.

Exact count values for each bit position, exact extracted and inserted fields at the boundary positions, the precise byte order of the swap, and the hold of the old output before the edge need the bench's directed scenarios with computed expected words.

// File: rtl/bfu_pkg.sv
// Shared encodings for the bit-field unit: operation codes and the
// selector values decoded inside the byte-shuffle group.
package bfu_pkg;

    typedef enum logic [2:0] {
        OP_LZERO   = 3'd0,
        OP_LONE    = 3'd1,
        OP_EXTRACT = 3'd2,
        OP_INSERT  = 3'd3,
        OP_SHUFFLE = 3'd4
    } bfu_op_e;

    localparam int SEL_W = 5;
    localparam logic [SEL_W-1:0] SHUF_SWAP   = 5'h02;
    localparam logic [SEL_W-1:0] SHUF_SEXT_B = 5'h10;
    localparam logic [SEL_W-1:0] SHUF_SEXT_H = 5'h18;

endpackage

// File: rtl/bfu_lead_count.sv
// Leading-run counter. Counts matching bits from the top bit down and
// stops at the first mismatch. MATCH_ONE selects whether ones or zeros
// are counted. Assumes WIDTH >= 2; a word made only of matching bits
// yields WIDTH.
module bfu_lead_count #(
    parameter int WIDTH     = 32,
    parameter bit MATCH_ONE = 1'b0,
    localparam int CW       = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] word,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] stop_bits;

    // Variant select: mark the bits that end the run.
    generate
        if (MATCH_ONE) begin : g_ones
            assign stop_bits = ~word;
        end else begin : g_zeros
            assign stop_bits = word;
        end
    endgenerate

    // Priority scan: the highest stop bit sets the count last.
    always_comb begin
        count = CW'(WIDTH);
        for (int i = 0; i < WIDTH; i++) begin
            if (stop_bits[i]) count = CW'(WIDTH - 1 - i);
        end
    end

endmodule

// File: rtl/bfu_field_unit.sv
// Variable bit-field extract and insert. Extract reads size-minus-one
// from fld_hi. Insert reads the top bit from fld_hi. Out-of-range bounds
// give a defined result and raise the matching bad flag. Assumes WIDTH
// is a power of two.
module bfu_field_unit #(
    parameter int WIDTH = 32,
    localparam int FW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [FW-1:0]    fld_hi,
    input  logic [FW-1:0]    fld_lo,
    output logic [WIDTH-1:0] ext_res,
    output logic             ext_bad,
    output logic [WIDTH-1:0] ins_res,
    output logic             ins_bad
);

    localparam logic [FW-1:0] TOP_IDX = FW'(WIDTH - 1);

    logic [FW:0]      ext_top;
    logic [WIDTH-1:0] ext_mask;
    logic [FW-1:0]    ins_span;
    logic [WIDTH-1:0] ins_low_mask;
    logic [WIDTH-1:0] ins_field_mask;

    // Extract: shift the field down and keep fld_hi+1 bits.
    always_comb begin
        ext_top  = {1'b0, fld_hi} + {1'b0, fld_lo};
        ext_bad  = ext_top > {1'b0, TOP_IDX};
        ext_mask = {WIDTH{1'b1}} >> (TOP_IDX - fld_hi);
        ext_res  = (src_a >> fld_lo) & ext_mask;
    end

    // Insert: replace bits fld_lo..fld_hi of src_b, or pass src_b on bad bounds.
    always_comb begin
        ins_bad        = fld_hi < fld_lo;
        ins_span       = fld_hi - fld_lo;
        ins_low_mask   = {WIDTH{1'b1}} >> (TOP_IDX - ins_span);
        ins_field_mask = ins_low_mask << fld_lo;
        if (ins_bad) begin
            ins_res = src_b;
        end else begin
            ins_res = (src_b & ~ins_field_mask) | ((src_a & ins_low_mask) << fld_lo);
        end
    end

endmodule

// File: rtl/bfu_byte_shuffle.sv
// Byte-shuffle group: swap bytes inside each halfword, or sign-extend
// the low byte or low halfword. Any other selector gives zero and sets
// bad. Assumes WIDTH is a multiple of 16.
module bfu_byte_shuffle #(
    parameter int WIDTH = 32,
    localparam int NHW  = WIDTH / 16
) (
    input  logic [WIDTH-1:0]          word,
    input  logic [bfu_pkg::SEL_W-1:0] sel,
    output logic [WIDTH-1:0]          res,
    output logic                      bad
);
    import bfu_pkg::*;

    logic [WIDTH-1:0] swapped;

    // One byte swap per halfword lane.
    generate
        for (genvar h = 0; h < NHW; h++) begin : g_lane
            assign swapped[16*h +: 8]     = word[16*h + 8 +: 8];
            assign swapped[16*h + 8 +: 8] = word[16*h +: 8];
        end
    endgenerate

    // Selector decode for the shuffle group.
    always_comb begin
        bad = 1'b0;
        case (sel)
            SHUF_SWAP:   res = swapped;
            SHUF_SEXT_B: res = {{(WIDTH-8){word[7]}}, word[7:0]};
            SHUF_SEXT_H: res = {{(WIDTH-16){word[15]}}, word[15:0]};
            default: begin
                res = '0;
                bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bitfield_unit.sv
// Bit-field and byte manipulation execution unit. The combinational
// operation units feed one output register. Reset is synchronous and
// active low. Reserved op codes give zero with the error flag set.
module bitfield_unit #(
    parameter int WIDTH = 32,
    localparam int FW   = $clog2(WIDTH),
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                op_sel,
    input  logic [WIDTH-1:0]          src_a,
    input  logic [WIDTH-1:0]          src_b,
    input  logic [bfu_pkg::SEL_W-1:0] shamt,
    input  logic [FW-1:0]             fld_hi,
    input  logic [FW-1:0]             fld_lo,
    output logic [WIDTH-1:0]          result,
    output logic                      field_err
);
    import bfu_pkg::*;

    logic [CW-1:0]    lz_cnt, lo_cnt;
    logic [WIDTH-1:0] ext_res, ins_res, shuf_res;
    logic             ext_bad, ins_bad, shuf_bad;
    logic [WIDTH-1:0] next_res;
    logic             next_err;
    bfu_op_e          op;

    bfu_lead_count #(.WIDTH(WIDTH), .MATCH_ONE(1'b0)) u_lzero (
        .word(src_a), .count(lz_cnt));

    bfu_lead_count #(.WIDTH(WIDTH), .MATCH_ONE(1'b1)) u_lone (
        .word(src_a), .count(lo_cnt));

    bfu_field_unit #(.WIDTH(WIDTH)) u_field (
        .src_a(src_a), .src_b(src_b), .fld_hi(fld_hi), .fld_lo(fld_lo),
        .ext_res(ext_res), .ext_bad(ext_bad),
        .ins_res(ins_res), .ins_bad(ins_bad));

    bfu_byte_shuffle #(.WIDTH(WIDTH)) u_shuf (
        .word(src_b), .sel(shamt), .res(shuf_res), .bad(shuf_bad));

    // Result mux: pick the unit named by the op code.
    always_comb begin
        op       = bfu_op_e'(op_sel);
        next_res = '0;
        next_err = 1'b0;
        case (op)
            OP_LZERO:   next_res = WIDTH'(lz_cnt);
            OP_LONE:    next_res = WIDTH'(lo_cnt);
            OP_EXTRACT: begin next_res = ext_res;  next_err = ext_bad;  end
            OP_INSERT:  begin next_res = ins_res;  next_err = ins_bad;  end
            OP_SHUFFLE: begin next_res = shuf_res; next_err = shuf_bad; end
            default:    next_err = 1'b1;
        endcase
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            field_err <= 1'b0;
        end else begin
            result    <= next_res;
            field_err <= next_err;
        end
    end

endmodule

// File: rtl/bfu_checker.sv
// Protocol checker for bitfield_unit. It relates each registered
// output to the inputs of the cycle before. It is attached by bind.
module bfu_checker #(
    parameter int WIDTH = 32,
    localparam int FW   = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] src_a,
    input logic [WIDTH-1:0] src_b,
    input logic [4:0]       shamt,
    input logic [FW-1:0]    fld_hi,
    input logic [FW-1:0]    fld_lo,
    input logic [WIDTH-1:0] result,
    input logic             field_err
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (result == '0 && !field_err));

    assert_lzero_top_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd0 && $past(src_a[WIDTH-1])) |-> (result == '0));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) <= 3'd1) |-> (result <= WIDTH && !field_err));

    assert_lone_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd1 && $past(src_a) == {WIDTH{1'b1}}) |-> (result == WIDTH));

    assert_extract_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd2 &&
         ({1'b0, $past(fld_hi)} + {1'b0, $past(fld_lo)}) > (FW+1)'(WIDTH - 1)) |-> field_err);

    assert_insert_reversed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd3 && $past(fld_hi) < $past(fld_lo))
        |-> (result == $past(src_b) && field_err));

    assert_swap_bits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd4 && $past(shamt) == 5'h02)
        |-> ($countones(result) == $countones($past(src_b)) && !field_err));

    assert_sext_byte_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd4 && $past(shamt) == 5'h10)
        |-> (result[WIDTH-1:8] == {(WIDTH-8){$past(src_b[7])}}));

    assert_sext_half_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd4 && $past(shamt) == 5'h18)
        |-> (result[WIDTH-1:16] == {(WIDTH-16){$past(src_b[15])}}));

    assert_reserved_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) >= 3'd5) |-> (result == '0 && field_err));

endmodule

bind bitfield_unit bfu_checker #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
    .shamt(shamt), .fld_hi(fld_hi), .fld_lo(fld_lo),
    .result(result), .field_err(field_err));

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [4:0]  shamt = '0, fld_hi = '0, fld_lo = '0;
    logic [31:0] result;
    logic        field_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    bitfield_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
        .shamt(shamt), .fld_hi(fld_hi), .fld_lo(fld_lo),
        .result(result), .field_err(field_err));

    task automatic compare(input string tag, input logic [31:0] exp_res, input logic exp_err);
        n_checks++;
        if (result !== exp_res || field_err !== exp_err) begin
            n_fails++;
            $display("FAIL %s: result=%h err=%b expected result=%h err=%b",
                     tag, result, field_err, exp_res, exp_err);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] sh, input logic [4:0] hi, input logic [4:0] lo,
                          input logic [31:0] exp_res, input logic exp_err, input string tag);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; shamt = sh; fld_hi = hi; fld_lo = lo;
        @(posedge clk);
        @(negedge clk);
        compare(tag, exp_res, exp_err);
    endtask

    task automatic test_reset_and_latency();
        @(negedge clk);
        compare("R1 reset value", 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        run_op(3'd0, 32'h0000_0100, '0, '0, '0, '0, 32'd23, 1'b0, "R1 first op");
        @(negedge clk);
        op_sel = 3'd0; src_a = 32'h8000_0000;
        #1;
        compare("R1 hold before edge", 32'd23, 1'b0);
        @(posedge clk);
        @(negedge clk);
        compare("R1 update after edge", 32'd0, 1'b0);
    endtask

    task automatic test_lead_zero();
        run_op(3'd0, 32'h0, '0, '0, '0, '0, 32'd32, 1'b0, "R2 all zero");
        run_op(3'd0, 32'h0001_F000, '0, '0, '0, '0, 32'd15, 1'b0, "R2 mixed");
        for (int i = 0; i < 32; i++) begin
            run_op(3'd0, 32'h1 << i, '0, '0, '0, '0, 32'(31 - i), 1'b0, "R2 single bit sweep");
        end
    endtask

    task automatic test_lead_one();
        run_op(3'd1, 32'hFFFF_FFFF, '0, '0, '0, '0, 32'd32, 1'b0, "R3 all ones");
        run_op(3'd1, 32'h7FFF_FFFF, '0, '0, '0, '0, 32'd0, 1'b0, "R3 top clear");
        run_op(3'd1, 32'hFFF0_0000, '0, '0, '0, '0, 32'd12, 1'b0, "R3 twelve ones");
        run_op(3'd1, 32'hFFFF_FFFE, '0, '0, '0, '0, 32'd31, 1'b0, "R3 low clear");
    endtask

    task automatic test_extract();
        run_op(3'd2, 32'hDEAD_BEEF, '0, '0, 5'd7,  5'd4,  32'h0000_00EE, 1'b0, "R4 byte field");
        run_op(3'd2, 32'hDEAD_BEEF, '0, '0, 5'd31, 5'd0,  32'hDEAD_BEEF, 1'b0, "R4 full word");
        run_op(3'd2, 32'hDEAD_BEEF, '0, '0, 5'd0,  5'd31, 32'h0000_0001, 1'b0, "R4 top bit only");
        run_op(3'd2, 32'hDEAD_BEEF, '0, '0, 5'd7,  5'd28, 32'h0000_000D, 1'b1, "R5 overrun");
        run_op(3'd2, 32'hDEAD_BEEF, '0, '0, 5'd31, 5'd16, 32'h0000_DEAD, 1'b1, "R5 overrun wide");
    endtask

    task automatic test_insert();
        run_op(3'd3, 32'h0, 32'hFFFF_FFFF, '0, 5'd15, 5'd8, 32'hFFFF_00FF, 1'b0, "R6 clear mid byte");
        run_op(3'd3, 32'h0000_ABCD, 32'h1234_5678, '0, 5'd31, 5'd16, 32'hABCD_5678, 1'b0, "R6 top half");
        run_op(3'd3, 32'h0000_0001, 32'h0, '0, 5'd0, 5'd0, 32'h0000_0001, 1'b0, "R6 one bit");
        run_op(3'd3, 32'hCAFE_F00D, 32'h1111_1111, '0, 5'd31, 5'd0, 32'hCAFE_F00D, 1'b0, "R6 full word");
        run_op(3'd3, 32'hFFFF_FFFF, 32'h1234_5678, '0, 5'd3, 5'd5, 32'h1234_5678, 1'b1, "R7 reversed bounds");
    endtask

    task automatic test_shuffle();
        run_op(3'd4, '0, 32'h1122_3344, 5'h02, '0, '0, 32'h2211_4433, 1'b0, "R8 swap");
        run_op(3'd4, '0, 32'h0000_0080, 5'h10, '0, '0, 32'hFFFF_FF80, 1'b0, "R9 byte negative");
        run_op(3'd4, '0, 32'h1234_567F, 5'h10, '0, '0, 32'h0000_007F, 1'b0, "R9 byte positive");
        run_op(3'd4, '0, 32'h0000_8001, 5'h18, '0, '0, 32'hFFFF_8001, 1'b0, "R9 half negative");
        run_op(3'd4, '0, 32'hFFFF_7FFF, 5'h18, '0, '0, 32'h0000_7FFF, 1'b0, "R9 half positive");
    endtask

    task automatic test_reserved();
        run_op(3'd4, '0, 32'h1122_3344, 5'h03, '0, '0, 32'h0, 1'b1, "R10 bad selector");
        run_op(3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, '0, '0, 32'h0, 1'b1, "R10 op 5");
        run_op(3'd7, 32'h1234_5678, 32'h1234_5678, 5'h02, '0, '0, 32'h0, 1'b1, "R10 op 7");
    endtask

    initial begin
        test_reset_and_latency();
        test_lead_zero();
        test_lead_one();
        test_extract();
        test_insert();
        test_shuffle();
        test_reserved();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: result=timeout expected result=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule